// File: doc/BRIEF.md
# Strobed Input Port Handshake

This block is an 8-bit input port for a peripheral that sends bytes with an active-low strobe. One system clock drives the whole block, and every input is already synchronised to it.

Each strobe pulse passes through a width qualifier before the block acts on it. A low pulse held for fewer than `MIN_PULSE` clock samples is discarded. Once a pulse has been low long enough, the block raises a buffer-full flag toward the peripheral. When the strobe returns high, the block captures the port byte. If interrupts are enabled at that moment, it also raises an active-high interrupt toward the processor.

The processor fetches the byte with an active-low read strobe. While the read strobe is low, the byte and a valid flag appear on the host bus. The falling edge of the read strobe withdraws the interrupt. The rising edge then releases the buffer-full flag, so the peripheral knows the byte has been taken.

Top module: `strobed_input_port`

## Requirements
- R1: After reset the held byte is 0x00, and both the buffer-full flag and the interrupt are 0. A read issued right after reset returns 0x00.
- R2: `full_flag` is 1 after the clock edge at which `stb_n` has been sampled low for `MIN_PULSE` consecutive edges. It stays 0 at the earlier edges of the pulse. A qualified rising edge also leaves it set.
- R3: A pulse is qualified when the strobe was low for at least `MIN_PULSE` samples. At the first clock edge that samples `stb_n` high after such a pulse, `port_din` is captured into the held byte.
- R4: At that same qualified rising edge, `irq` is set to 1 if `irq_en` is 1. If `irq_en` is 0, `irq` keeps its value.
- R5: At the clock edge where `rd_n` is first sampled low after being high, `irq` is cleared. `full_flag` is left unchanged at that edge.
- R6: At the clock edge where `rd_n` is first sampled high after being low, `full_flag` is cleared.
- R7: A strobe pulse shorter than `MIN_PULSE` samples has no effect. It leaves the held byte, `full_flag` and `irq` unchanged.
- R8: While `rd_n` is 0, `host_dout` equals the held byte and `host_valid` is 1. While `rd_n` is 1, both are 0.
- R9: A qualified strobe that arrives while `full_flag` is 1 overwrites the held byte, and `full_flag` stays 1 throughout.
- R10: When a set event and a clear event for the same indication fall on one clock edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_n | input | 1 | Peripheral data strobe, active low |
| port_din | input | DATA_W | Peripheral data byte |
| irq_en | input | 1 | Interrupt enable |
| rd_n | input | 1 | Processor read strobe, active low |
| host_dout | output | DATA_W | Held byte while reading, zero otherwise |
| host_valid | output | 1 | High while a read is in progress |
| full_flag | output | 1 | Input buffer full, toward the peripheral |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with `DATA_W = 8` and `MIN_PULSE = 3`. At that size every strobe width from one sample up to twice the threshold can be swept, along with both interrupt-enable settings. All 256 byte values can also be captured and read back one by one. A threshold of three leaves room to line up a read edge with a qualified strobe edge on the same clock, which is how the set-over-clear priority is exercised.

// File: rtl/sip_pkg.sv
`timescale 1ns/1ps
package sip_pkg;
  // Counter width needed to hold values 0..lim.
  function automatic int run_width(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  // Saturating step of a low-run counter.
  function automatic int unsigned run_step(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // A pulse qualifies once its low run reaches the limit.
  function automatic bit run_done(input int unsigned cur, input int unsigned lim);
    return cur >= lim;
  endfunction
endpackage

// File: rtl/sip_pulse_qual.sv
`timescale 1ns/1ps
module sip_pulse_qual #(
  parameter int MIN_PULSE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_n,
  output logic fall_qual,
  output logic rise_qual
);
  localparam int CW = sip_pkg::run_width(MIN_PULSE);

  logic [CW-1:0] low_run;
  logic [CW-1:0] low_next;

  always_comb begin
    low_next = CW'(sip_pkg::run_step(32'(low_run), 32'(MIN_PULSE)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_run <= '0;
    else if (stb_n) low_run <= '0;
    else            low_run <= low_next;
  end

  // The low run reaches the threshold at this edge.
  assign fall_qual = !stb_n && !sip_pkg::run_done(32'(low_run), 32'(MIN_PULSE))
                     && sip_pkg::run_done(32'(low_next), 32'(MIN_PULSE));
  // The strobe returns high after a pulse that met the threshold.
  assign rise_qual = stb_n && sip_pkg::run_done(32'(low_run), 32'(MIN_PULSE));

  assert_run_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(low_run) <= 32'(MIN_PULSE));
  assert_rise_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_n |=> !rise_qual);
endmodule

// File: rtl/sip_edge_det.sv
`timescale 1ns/1ps
module sip_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n,
  output logic rd_fall,
  output logic rd_rise
);
  logic rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b1;
    else        rd_q <= rd_n;
  end

  assign rd_fall = rd_q && !rd_n;
  assign rd_rise = !rd_q && rd_n;

  assert_edges_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall |=> !rd_fall);
endmodule

// File: rtl/sip_hold_regs.sv
`timescale 1ns/1ps
module sip_hold_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_qual,
  input  logic              rise_qual,
  input  logic              irq_en,
  input  logic              rd_fall,
  input  logic              rd_rise,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] held,
  output logic              full_flag,
  output logic              irq
);
  logic full_set, irq_set;

  assign full_set = fall_qual || rise_qual;
  assign irq_set  = rise_qual && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= '0;
      full_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (rise_qual) held <= din;
      // Set takes priority over clear (R10).
      if (full_set)     full_flag <= 1'b1;
      else if (rd_rise) full_flag <= 1'b0;
      if (irq_set)      irq <= 1'b1;
      else if (rd_fall) irq <= 1'b0;
    end
  end

  assert_full_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_qual |=> full_flag);
  assert_take_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_qual |=> held == $past(din));
  assert_irq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_qual && irq_en) |=> irq);
  assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(rise_qual && irq_en)) |=> !irq);
  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !(rise_qual && irq_en)) |=> !irq);
  assert_full_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && full_flag) |=> full_flag);
  assert_full_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && !fall_qual && !rise_qual) |=> !full_flag);
  assert_byte_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_qual |=> $stable(held));
endmodule

// File: rtl/sip_bus_drive.sv
`timescale 1ns/1ps
module sip_bus_drive #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] held,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_valid
);
  always_comb begin
    host_valid = !rd_n;
    host_dout  = rd_n ? '0 : held;
  end

  assert_idle_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> (host_dout == '0 && !host_valid));
  assert_read_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (host_valid && host_dout == held));
endmodule

// File: rtl/strobed_input_port.sv
`timescale 1ns/1ps
module strobed_input_port #(
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_n,
  input  logic [DATA_W-1:0] port_din,
  input  logic              irq_en,
  input  logic              rd_n,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_valid,
  output logic              full_flag,
  output logic              irq
);
  logic fall_qual, rise_qual, rd_fall, rd_rise;
  logic [DATA_W-1:0] held;

  sip_pulse_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n),
    .fall_qual(fall_qual), .rise_qual(rise_qual));

  sip_edge_det u_rd (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n),
    .rd_fall(rd_fall), .rd_rise(rd_rise));

  sip_hold_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .fall_qual(fall_qual), .rise_qual(rise_qual),
    .irq_en(irq_en), .rd_fall(rd_fall), .rd_rise(rd_rise), .din(port_din),
    .held(held), .full_flag(full_flag), .irq(irq));

  sip_bus_drive #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .held(held),
    .host_dout(host_dout), .host_valid(host_valid));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_qual && rd_rise) |=> full_flag);
endmodule

// File: tb/strobed_input_port_test.sv
`timescale 1ns/1ps
module strobed_input_port_test;
  localparam int MIN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb_n = 1'b1;
  logic [7:0] port_din = '0;
  logic irq_en = 1'b0;
  logic rd_n = 1'b1;
  logic [7:0] host_dout;
  logic host_valid, full_flag, irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_byte = '0;
  logic exp_full = 1'b0;
  logic exp_irq = 1'b0;

  always #4 clk = ~clk;

  strobed_input_port #(.DATA_W(8), .MIN_PULSE(MIN)) uut (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .port_din(port_din),
    .irq_en(irq_en), .rd_n(rd_n), .host_dout(host_dout),
    .host_valid(host_valid), .full_flag(full_flag), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Strobe pulse of w low samples carrying byte d.
  task automatic pulse(input int w, input logic [7:0] d, input logic en);
    logic was_full;
    was_full = exp_full;
    irq_en = en;
    port_din = d;
    stb_n = 1'b0;
    for (int i = 1; i <= w; i++) begin
      @(negedge clk);
      if (!was_full) chk("R2", 32'(full_flag), 32'(i >= MIN));
      else           chk("R9", 32'(full_flag), 32'd1);
    end
    stb_n = 1'b1;
    @(negedge clk);
    port_din = ~d;
    if (w >= MIN) begin
      exp_full = 1'b1;
      exp_byte = d;
      if (en) exp_irq = 1'b1;
      chk("R4", 32'(irq), 32'(exp_irq));
    end else begin
      chk("R7", 32'(irq), 32'(exp_irq));
      chk("R7", 32'(full_flag), 32'(exp_full));
    end
  endtask

  task automatic do_read(input string tag);
    rd_n = 1'b0;
    #1;
    chk("R8", 32'(host_valid), 32'd1);
    chk(tag, 32'(host_dout), 32'(exp_byte));
    @(negedge clk);
    exp_irq = 1'b0;
    chk("R5", 32'(irq), 32'd0);
    chk("R5", 32'(full_flag), 32'(exp_full));
    rd_n = 1'b1;
    #1;
    chk("R8", 32'(host_dout), 32'd0);
    chk("R8", 32'(host_valid), 32'd0);
    @(negedge clk);
    exp_full = 1'b0;
    chk("R6", 32'(full_flag), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", 32'(full_flag), 32'd0);
    chk("R1", 32'(irq), 32'd0);
    chk("R1", 32'(host_dout), 32'd0);
    do_read("R1");

    // R7 and R2: sweep of pulse widths and enable settings
    for (int w = 1; w <= 2 * MIN; w++) begin
      pulse(w, 8'(w * 37 + 5), 1'(w % 2));
      do_read(w >= MIN ? "R3" : "R7");
    end

    // R3: every byte value
    for (int v = 0; v < 256; v++) begin
      pulse(MIN, 8'(v), 1'b1);
      do_read("R3");
    end

    // R9: overwrite while full
    pulse(MIN, 8'h11, 1'b1);
    pulse(MIN + 1, 8'h22, 1'b0);
    chk("R9", 32'(full_flag), 32'd1);
    do_read("R9");

    // R10: set and clear on the same edge
    irq_en = 1'b1;
    port_din = 8'hA5;
    rd_n = 1'b0;
    stb_n = 1'b0;
    repeat (MIN - 1) @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    chk("R10", 32'(full_flag), 32'd1);
    rd_n = 1'b0;
    stb_n = 1'b1;
    @(negedge clk);
    chk("R10", 32'(irq), 32'd1);
    chk("R3", 32'(host_dout), 32'hA5);
    rd_n = 1'b1;
    @(negedge clk);
    chk("R6", 32'(full_flag), 32'd0);
    exp_byte = 8'hA5;
    exp_irq = 1'b1;
    exp_full = 1'b0;
    do_read("R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule